// File: doc/BRIEF.md
# Microinstruction Register-Transfer Datapath

This block is the register-transfer half of a microprogrammed processor. Each cycle it receives three 3-bit operation selectors, taken from one control word, and applies every transfer they name on the next rising clock edge. It holds a 16-bit accumulator, a 16-bit data register, an 11-bit address register, an 11-bit program counter, and a 2048-word by 16-bit main memory addressed by the address register. A separate sequencer supplies the selectors and reads back three status bits: the accumulator sign, accumulator-is-zero, and the data-register sign. The data-register sign is where a fetched instruction word keeps its indirect flag.

All three selectors see the register values from before the edge. Two transfers in one control word can therefore exchange registers without a temporary. If more than one selector targets the accumulator, a fixed priority picks one.

Top module: `uop_xfer_path`

## Requirements
- R1: A synchronous active-low reset `rstN` clears the accumulator, data register, address register and program counter to zero at the clock edge. Memory contents are left untouched.
- R2: Selector A codes: 0 nothing; 1 acc <= acc + dat; 2 acc <= 0; 3 acc <= acc + 1; 4 acc <= dat; 5 adr <= dat[10:0]; 6 adr <= pc; 7 mem[adr] <= dat.
- R3: Selector B codes: 0 nothing; 1 acc <= acc - dat; 2 acc <= acc | dat; 3 acc <= acc & dat; 4 dat <= mem[adr]; 5 dat <= acc; 6 dat <= dat + 1; 7 dat[10:0] <= pc.
- R4: Selector C codes: 0 nothing; 1 acc <= acc ^ dat; 2 acc <= ~acc; 3 acc shift left by one; 4 acc shift right by one; 5 pc <= pc + 1; 6 pc <= adr. Code 7 has no effect on any register.
- R5: Every transfer reads values from before the edge. A=4 with B=5 swaps acc and dat. A=6 with C=6 swaps adr and pc.
- R6: When more than one selector writes the accumulator, selector A wins over B, and B wins over C. A losing selector's accumulator operation is dropped.
- R7: Shifts fill the vacated bit with 0. Add, subtract and increment wrap modulo 2^16.
- R8: A memory write takes effect at the edge. A read of the same word in the same cycle returns the word held before the write.
- R9: Code B=7 leaves dat[15:11] unchanged.
- R10: `accNeg` = acc[15], `accIsZero` = (acc == 0) and `datNeg` = dat[15], all taken from the current register values.
- R11: adr changes only for A=5 or A=6. pc changes only for C=5 or C=6. dat changes only for B codes 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opSelA | input | 3 | Selector A (accumulator, address register, memory write) |
| opSelB | input | 3 | Selector B (ALU with dat, data register loads) |
| opSelC | input | 3 | Selector C (logic, shifts, program counter) |
| accOut | output | 16 | Accumulator |
| datOut | output | 16 | Data register |
| adrOut | output | 11 | Address register |
| pcOut | output | 11 | Program counter |
| accNeg | output | 1 | Accumulator sign bit |
| accIsZero | output | 1 | Accumulator equals zero |
| datNeg | output | 1 | Data register bit 15 |

## Verification
Every register result is due one edge after the selectors are applied, because selectors are decoded combinationally and the registers load at that edge. The status bits follow the registers with no further delay. The bench drives selectors on the falling edge and samples all outputs on the next falling edge, half a period after the loading edge. A memory write becomes visible only through a read one or more cycles later, so the bench reads back in a later control word, and it also tests a write and read in the same word.

// File: rtl/mop_pkg.sv
package mop_pkg;

  localparam logic [2:0] SELA_ADD   = 3'd1;
  localparam logic [2:0] SELA_CLR   = 3'd2;
  localparam logic [2:0] SELA_INC   = 3'd3;
  localparam logic [2:0] SELA_DAT   = 3'd4;
  localparam logic [2:0] SELA_ADRD  = 3'd5;
  localparam logic [2:0] SELA_ADRP  = 3'd6;
  localparam logic [2:0] SELA_WR    = 3'd7;

  localparam logic [2:0] SELB_SUB   = 3'd1;
  localparam logic [2:0] SELB_OR    = 3'd2;
  localparam logic [2:0] SELB_AND   = 3'd3;
  localparam logic [2:0] SELB_RD    = 3'd4;
  localparam logic [2:0] SELB_ACC   = 3'd5;
  localparam logic [2:0] SELB_INC   = 3'd6;
  localparam logic [2:0] SELB_PCLO  = 3'd7;

  localparam logic [2:0] SELC_XOR   = 3'd1;
  localparam logic [2:0] SELC_NOT   = 3'd2;
  localparam logic [2:0] SELC_SHL   = 3'd3;
  localparam logic [2:0] SELC_SHR   = 3'd4;
  localparam logic [2:0] SELC_PINC  = 3'd5;
  localparam logic [2:0] SELC_PADR  = 3'd6;

  typedef enum logic [3:0] {
    AC_KEEP, AC_ADD, AC_ZERO, AC_INC, AC_LOAD_DAT, AC_SUB,
    AC_OR, AC_AND, AC_XOR, AC_NOT, AC_SHL, AC_SHR
  } acOp_e;

  typedef enum logic [2:0] {
    DT_KEEP, DT_MEM, DT_ACC, DT_INC, DT_PCLOW
  } datOp_e;

  typedef enum logic [1:0] {
    AD_KEEP, AD_DATLOW, AD_PC
  } adrOp_e;

  typedef enum logic [1:0] {
    PC_KEEP, PC_INC, PC_ADR
  } pcOp_e;

  typedef struct packed {
    acOp_e  acOp;
    datOp_e datOp;
    adrOp_e adrOp;
    pcOp_e  pcOp;
    logic   memWr;
  } mopStrobe_t;

endpackage

// File: rtl/mop_decode.sv
module mop_decode
  import mop_pkg::*;
(
  input  logic [2:0] selA,
  input  logic [2:0] selB,
  input  logic [2:0] selC,
  output mopStrobe_t strobe
);

  acOp_e  acFromA, acFromB, acFromC;
  datOp_e datSel;
  adrOp_e adrSel;
  pcOp_e  pcSel;
  logic   wrSel;

  always_comb begin
    acFromA = AC_KEEP;
    adrSel  = AD_KEEP;
    wrSel   = 1'b0;
    case (selA)
      SELA_ADD:  acFromA = AC_ADD;
      SELA_CLR:  acFromA = AC_ZERO;
      SELA_INC:  acFromA = AC_INC;
      SELA_DAT:  acFromA = AC_LOAD_DAT;
      SELA_ADRD: adrSel  = AD_DATLOW;
      SELA_ADRP: adrSel  = AD_PC;
      SELA_WR:   wrSel   = 1'b1;
      default:   ;
    endcase
  end

  always_comb begin
    acFromB = AC_KEEP;
    datSel  = DT_KEEP;
    case (selB)
      SELB_SUB:  acFromB = AC_SUB;
      SELB_OR:   acFromB = AC_OR;
      SELB_AND:  acFromB = AC_AND;
      SELB_RD:   datSel  = DT_MEM;
      SELB_ACC:  datSel  = DT_ACC;
      SELB_INC:  datSel  = DT_INC;
      SELB_PCLO: datSel  = DT_PCLOW;
      default:   ;
    endcase
  end

  always_comb begin
    acFromC = AC_KEEP;
    pcSel   = PC_KEEP;
    case (selC)
      SELC_XOR:  acFromC = AC_XOR;
      SELC_NOT:  acFromC = AC_NOT;
      SELC_SHL:  acFromC = AC_SHL;
      SELC_SHR:  acFromC = AC_SHR;
      SELC_PINC: pcSel   = PC_INC;
      SELC_PADR: pcSel   = PC_ADR;
      default:   ;
    endcase
  end

  // accumulator writer priority: A, then B, then C
  always_comb begin
    if (acFromA != AC_KEEP)      strobe.acOp = acFromA;
    else if (acFromB != AC_KEEP) strobe.acOp = acFromB;
    else                         strobe.acOp = acFromC;
    strobe.datOp = datSel;
    strobe.adrOp = adrSel;
    strobe.pcOp  = pcSel;
    strobe.memWr = wrSel;
  end

endmodule

// File: rtl/mop_acunit.sv
module mop_acunit
  import mop_pkg::*;
#(
  parameter int DW = 16
) (
  input  acOp_e         op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] dat,
  output logic [DW-1:0] accNext
);

  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    case (op)
      AC_ADD:      accNext = acc + dat;
      AC_ZERO:     accNext = '0;
      AC_INC:      accNext = acc + ONE;
      AC_LOAD_DAT: accNext = dat;
      AC_SUB:      accNext = acc - dat;
      AC_OR:       accNext = acc | dat;
      AC_AND:      accNext = acc & dat;
      AC_XOR:      accNext = acc ^ dat;
      AC_NOT:      accNext = ~acc;
      AC_SHL:      accNext = {acc[DW-2:0], 1'b0};
      AC_SHR:      accNext = {1'b0, acc[DW-1:1]};
      default:     accNext = acc;
    endcase
  end

endmodule

// File: rtl/mop_mainmem.sv
module mop_mainmem #(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[addr] <= wrData;
  end

  assign rdData = store[addr];

endmodule

// File: rtl/mop_datapath.sv
module mop_datapath
  import mop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  mopStrobe_t    strobe,
  output logic [DW-1:0] accQ,
  output logic [DW-1:0] datQ,
  output logic [AW-1:0] adrQ,
  output logic [AW-1:0] pcQ
);

  localparam logic [DW-1:0] DONE = DW'(1);
  localparam logic [AW-1:0] AONE = AW'(1);

  logic [DW-1:0] accNext;
  logic [DW-1:0] memRd;

  mop_acunit #(.DW(DW)) uAcc (
    .op      (strobe.acOp),
    .acc     (accQ),
    .dat     (datQ),
    .accNext (accNext)
  );

  mop_mainmem #(.DW(DW), .AW(AW)) uMem (
    .clk    (clk),
    .wrEn   (strobe.memWr),
    .addr   (adrQ),
    .wrData (datQ),
    .rdData (memRd)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      datQ <= '0;
      adrQ <= '0;
      pcQ  <= '0;
    end else begin
      accQ <= accNext;
      case (strobe.datOp)
        DT_MEM:   datQ <= memRd;
        DT_ACC:   datQ <= accQ;
        DT_INC:   datQ <= datQ + DONE;
        DT_PCLOW: datQ <= {datQ[DW-1:AW], pcQ};
        default:  ;
      endcase
      case (strobe.adrOp)
        AD_DATLOW: adrQ <= datQ[AW-1:0];
        AD_PC:     adrQ <= pcQ;
        default:   ;
      endcase
      case (strobe.pcOp)
        PC_INC:  pcQ <= pcQ + AONE;
        PC_ADR:  pcQ <= adrQ;
        default: ;
      endcase
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (accQ == '0 && datQ == '0 && adrQ == '0 && pcQ == '0));

  a_r11_pc_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pcOp == PC_KEEP) |=> $stable(pcQ));

  a_r11_adr_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.adrOp == AD_KEEP) |=> $stable(adrQ));

  a_r9_dat_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.datOp == DT_PCLOW) |=> (datQ[DW-1:AW] == $past(datQ[DW-1:AW])));

  a_r5_acc_dat_swap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.acOp == AC_LOAD_DAT && strobe.datOp == DT_ACC)
      |=> (accQ == $past(datQ) && datQ == $past(accQ)));

endmodule

// File: rtl/uop_xfer_path.sv
module uop_xfer_path
  import mop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    opSelA,
  input  logic [2:0]    opSelB,
  input  logic [2:0]    opSelC,
  output logic [DW-1:0] accOut,
  output logic [DW-1:0] datOut,
  output logic [AW-1:0] adrOut,
  output logic [AW-1:0] pcOut,
  output logic          accNeg,
  output logic          accIsZero,
  output logic          datNeg
);

  mopStrobe_t strobe;

  mop_decode uDec (
    .selA   (opSelA),
    .selB   (opSelB),
    .selC   (opSelC),
    .strobe (strobe)
  );

  mop_datapath #(.DW(DW), .AW(AW)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .accQ   (accOut),
    .datQ   (datOut),
    .adrQ   (adrOut),
    .pcQ    (pcOut)
  );

  assign accNeg    = accOut[DW-1];
  assign accIsZero = (accOut == '0);
  assign datNeg    = datOut[DW-1];

  a_r7_shl_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    (opSelA == 3'd0 && opSelB == 3'd0 && opSelC == SELC_SHL) |=> (accOut[0] == 1'b0));

  a_r7_shr_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    (opSelA == 3'd0 && opSelB == 3'd0 && opSelC == SELC_SHR) |=> (accOut[DW-1] == 1'b0));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (opSelA == SELA_CLR) |=> (accOut == '0));

  a_r4_reserved_idle: assert property (@(posedge clk) disable iff (!rstN)
    (opSelA == 3'd0 && opSelB == 3'd0 && opSelC == 3'd7)
      |=> ($stable(accOut) && $stable(datOut) && $stable(adrOut) && $stable(pcOut)));

endmodule

// File: tb/sim_uop_xfer_path.sv
module sim_uop_xfer_path;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opSelA = '0, opSelB = '0, opSelC = '0;
  logic [15:0] accOut, datOut;
  logic [10:0] adrOut, pcOut;
  logic        accNeg, accIsZero, datNeg;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  uop_xfer_path u0 (
    .clk(clk), .rstN(rstN),
    .opSelA(opSelA), .opSelB(opSelB), .opSelC(opSelC),
    .accOut(accOut), .datOut(datOut), .adrOut(adrOut), .pcOut(pcOut),
    .accNeg(accNeg), .accIsZero(accIsZero), .datNeg(datNeg)
  );

  // {selA, selB, selC, acc, dat, adr, pc} after the edge
  localparam int NV = 30;
  localparam logic [62:0] VEC [NV] = '{
    {3'd3, 3'd0, 3'd0, 16'h0001, 16'h0000, 11'h000, 11'h000},
    {3'd0, 3'd0, 3'd3, 16'h0002, 16'h0000, 11'h000, 11'h000},
    {3'd0, 3'd0, 3'd3, 16'h0004, 16'h0000, 11'h000, 11'h000},
    {3'd0, 3'd5, 3'd5, 16'h0004, 16'h0004, 11'h000, 11'h001},
    {3'd1, 3'd0, 3'd0, 16'h0008, 16'h0004, 11'h000, 11'h001},
    {3'd0, 3'd6, 3'd0, 16'h0008, 16'h0005, 11'h000, 11'h001},
    {3'd4, 3'd5, 3'd0, 16'h0005, 16'h0008, 11'h000, 11'h001},
    {3'd0, 3'd0, 3'd1, 16'h000D, 16'h0008, 11'h000, 11'h001},
    {3'd0, 3'd0, 3'd2, 16'hFFF2, 16'h0008, 11'h000, 11'h001},
    {3'd0, 3'd0, 3'd4, 16'h7FF9, 16'h0008, 11'h000, 11'h001},
    {3'd0, 3'd3, 3'd0, 16'h0008, 16'h0008, 11'h000, 11'h001},
    {3'd0, 3'd1, 3'd0, 16'h0000, 16'h0008, 11'h000, 11'h001},
    {3'd5, 3'd0, 3'd0, 16'h0000, 16'h0008, 11'h008, 11'h001},
    {3'd7, 3'd0, 3'd0, 16'h0000, 16'h0008, 11'h008, 11'h001},
    {3'd0, 3'd7, 3'd0, 16'h0000, 16'h0001, 11'h008, 11'h001},
    {3'd0, 3'd4, 3'd0, 16'h0000, 16'h0008, 11'h008, 11'h001},
    {3'd6, 3'd0, 3'd6, 16'h0000, 16'h0008, 11'h001, 11'h008},
    {3'd3, 3'd0, 3'd7, 16'h0001, 16'h0008, 11'h001, 11'h008},
    {3'd2, 3'd1, 3'd1, 16'h0000, 16'h0008, 11'h001, 11'h008},
    {3'd0, 3'd2, 3'd3, 16'h0008, 16'h0008, 11'h001, 11'h008},
    {3'd0, 3'd0, 3'd2, 16'hFFF7, 16'h0008, 11'h001, 11'h008},
    {3'd0, 3'd5, 3'd0, 16'hFFF7, 16'hFFF7, 11'h001, 11'h008},
    {3'd0, 3'd7, 3'd0, 16'hFFF7, 16'hF808, 11'h001, 11'h008},
    {3'd0, 3'd0, 3'd3, 16'hFFEE, 16'hF808, 11'h001, 11'h008},
    {3'd2, 3'd0, 3'd0, 16'h0000, 16'hF808, 11'h001, 11'h008},
    {3'd0, 3'd0, 3'd2, 16'hFFFF, 16'hF808, 11'h001, 11'h008},
    {3'd3, 3'd0, 3'd0, 16'h0000, 16'hF808, 11'h001, 11'h008},
    {3'd5, 3'd0, 3'd0, 16'h0000, 16'hF808, 11'h008, 11'h008},
    {3'd7, 3'd4, 3'd0, 16'h0000, 16'h0008, 11'h008, 11'h008},
    {3'd0, 3'd4, 3'd0, 16'h0000, 16'hF808, 11'h008, 11'h008}
  };

  function automatic string rowTag(int i);
    case (i)
      0, 4, 12, 24:           return "R2";
      5, 10, 11, 14, 21:      return "R3";
      7, 8, 17, 20, 25:       return "R4";
      3, 6, 16:               return "R5";
      18, 19:                 return "R6";
      1, 2, 9, 23, 26:        return "R7";
      13, 15, 28, 29:         return "R8";
      22:                     return "R9";
      default:                return "R11";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic checkRegs(string tag, logic [15:0] eAcc, logic [15:0] eDat,
                           logic [10:0] eAdr, logic [10:0] ePc);
    check(tag, "acc", accOut, eAcc);
    check(tag, "dat", datOut, eDat);
    check(tag, "adr", {5'd0, adrOut}, {5'd0, eAdr});
    check(tag, "pc",  {5'd0, pcOut},  {5'd0, ePc});
    // R10 status bits from expected register values
    check("R10", "status", {13'd0, accNeg, accIsZero, datNeg},
          {13'd0, eAcc[15], (eAcc == 16'd0), eDat[15]});
  endtask

  task automatic step(logic [2:0] a, logic [2:0] b, logic [2:0] c);
    opSelA = a; opSelB = b; opSelC = c;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkRegs("R1", 16'h0, 16'h0, 11'h0, 11'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][62:60], VEC[i][59:57], VEC[i][56:54]);
      checkRegs(rowTag(i), VEC[i][53:38], VEC[i][37:22], VEC[i][21:11], VEC[i][10:0]);
    end

    // R1: reset mid-run clears registers
    opSelA = 3'd0; opSelB = 3'd0; opSelC = 3'd0;
    rstN = 1'b0;
    @(negedge clk);
    checkRegs("R1", 16'h0, 16'h0, 11'h0, 11'h0);
    rstN = 1'b1;

    // R1 and R8: memory word 8 survives reset
    step(3'd3, 3'd0, 3'd0);
    step(3'd0, 3'd0, 3'd3);
    step(3'd0, 3'd0, 3'd3);
    step(3'd0, 3'd0, 3'd3);
    check("R7", "acc", accOut, 16'h0008);
    step(3'd0, 3'd5, 3'd0);
    step(3'd5, 3'd0, 3'd0);
    check("R2", "adr", {5'd0, adrOut}, 16'h0008);
    step(3'd0, 3'd4, 3'd0);
    check("R1", "mem kept", datOut, 16'hF808);

    // R7: dat increment wraps
    step(3'd0, 3'd0, 3'd2);
    step(3'd0, 3'd5, 3'd0);
    check("R3", "dat", datOut, 16'hFFF7);
    for (int k = 0; k < 9; k++) step(3'd0, 3'd6, 3'd0);
    check("R7", "dat wrap", datOut, 16'h0000);

    // R11: idle word leaves every register unchanged
    step(3'd0, 3'd0, 3'd0);
    checkRegs("R11", 16'hFFF7, 16'h0000, 11'h008, 11'h000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule